// File: doc/BRIEF.md
# Wiper Position Counter with Tap Select Decoder

This block holds the volatile position of a digitally controlled resistor wiper and turns it into the enable pattern for the tap switches along the resistor string. Exactly one switch is closed at any time. Code zero selects the tap at the low end of the string. The all-ones code selects the tap at the high end.

The position can change in four ways. A bus command controller writes a new value directly. A transfer copies one entry of an attached bank of stored settings. A step command moves the wiper one tap up or down. After every reset, a power-on recall waits a fixed number of cycles and then copies bank entry 0 into the register. The bank itself and the serial protocol sit outside this block. The current position is available as a plain output so that the controller can read it back or store it into the bank.

Top module: `wiper_position_unit`

## Requirements
- R1: While reset is high, `pos_out` is 0 and `tap_sel` has only bit 0 set.
- R2: After reset falls, the block waits RECALL_WAIT (default 4) clock edges and loads bank entry 0 on the next edge. Write, transfer and step strobes have no effect until that load. The load ignores the position held before reset.
- R3: When `host_wr_en` is high, `pos_out` equals `host_wr_data` after the next rising edge.
- R4: When `xfer_en` is high, `pos_out` takes bank entry `xfer_sel` after the next edge. Entry k occupies `bank_data[k*6 +: 6]`.
- R5: When `step_en` is high, the position rises by one if `step_up` is 1 and falls by one if `step_up` is 0.
- R6: A step up from 3Fh leaves the position at 3Fh. A step down from 00h leaves it at 00h.
- R7: When strobes coincide, the order of precedence is recall, then direct write, then transfer, then step.
- R8: `tap_sel` has exactly one bit set, at index `pos_out`. Bit 0 is the low terminal and bit 63 is the high terminal.
- R9: In a cycle with no strobe, the position holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the recall sequence when it falls |
| host_wr_en | input | 1 | Direct write strobe |
| host_wr_data | input | 6 | Value for a direct write |
| xfer_en | input | 1 | Transfer strobe, copies a bank entry |
| xfer_sel | input | 2 | Bank entry selected for the transfer |
| bank_data | input | 24 | All bank entries, packed; entry k at bits k*6 +: 6 |
| step_en | input | 1 | Single-step strobe |
| step_up | input | 1 | Step direction: 1 moves toward the high end, 0 toward the low end |
| pos_out | output | 6 | Current wiper position |
| tap_sel | output | 64 | One-hot tap switch enables |

## Verification
A strobe applied before a rising edge shows on `pos_out` and `tap_sel` just after that edge. There is one register stage and the decode is combinational. The bench therefore drives inputs on the falling edge, waits for one rising edge, and samples on the following falling edge. The power-on recall is due on the fifth rising edge after reset falls. The bench counts those edges exactly. It samples once on the fourth edge, to show the position is still held while strobes are active, and once on the fifth, where the bank entry must appear.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    // Source that updates the position register in a given cycle
    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_RECALL = 3'd1,
        SRC_WRITE  = 3'd2,
        SRC_XFER   = 3'd3,
        SRC_STEP   = 3'd4
    } pos_src_e;

    // Strobes seen by the update selector
    typedef struct packed {
        logic wr;
        logic xfer;
        logic step;
        logic up;
    } pos_req_t;

    // Saturating single step on an unsigned position of any width up to 32
    function automatic int unsigned sat_step(int unsigned cur, logic up, int unsigned top);
        if (up)
            return (cur >= top) ? top : cur + 1;
        else
            return (cur == 0) ? 0 : cur - 1;
    endfunction

endpackage

// File: rtl/wiper_recall_seq.sv
module wiper_recall_seq #(
    parameter int RECALL_WAIT = 4
) (
    input  logic clk,
    input  logic rst,
    output logic busy,
    output logic fire
);
    localparam int CNT_W = $clog2(RECALL_WAIT + 2);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= CNT_W'(RECALL_WAIT);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign fire = busy_q && (cnt_q == '0);

    // R2
    recall_once_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !busy);

endmodule

// File: rtl/wiper_next_sel.sv
module wiper_next_sel
    import wiper_pkg::*;
#(
    parameter int POS_W  = 6,
    parameter int BANK_N = 4
) (
    input  logic                      busy,
    input  logic                      fire,
    input  pos_req_t                  req,
    input  logic [POS_W-1:0]          wr_data,
    input  logic [$clog2(BANK_N)-1:0] xfer_sel,
    input  logic [BANK_N*POS_W-1:0]   bank_data,
    input  logic [POS_W-1:0]          cur,
    output pos_src_e                  src,
    output logic [POS_W-1:0]          nxt
);
    localparam int unsigned POS_TOP = (1 << POS_W) - 1;

    logic [POS_W-1:0] bank_entry [BANK_N];
    logic [POS_W-1:0] stepped;

    for (genvar k = 0; k < BANK_N; k++) begin : g_entry
        assign bank_entry[k] = bank_data[k*POS_W +: POS_W];
    end

    always_comb begin
        stepped = POS_W'(sat_step(32'(cur), req.up, POS_TOP));
    end

    always_comb begin
        src = SRC_HOLD;
        nxt = cur;
        if (fire) begin
            src = SRC_RECALL;
            nxt = bank_entry[0];
        end else if (!busy) begin
            if (req.wr) begin
                src = SRC_WRITE;
                nxt = wr_data;
            end else if (req.xfer) begin
                src = SRC_XFER;
                nxt = bank_entry[xfer_sel];
            end else if (req.step) begin
                src = SRC_STEP;
                nxt = stepped;
            end
        end
    end

endmodule

// File: rtl/wiper_tap_decoder.sv
module wiper_tap_decoder #(
    parameter int POS_W = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [POS_W-1:0]      pos,
    output logic [(1<<POS_W)-1:0] taps
);
    localparam int TAPS = 1 << POS_W;

    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        assign taps[i] = (pos == POS_W'(i));
    end

    // R8
    onehot_tap_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot(taps));

    // R1
    reset_tap_chk: assert property (@(posedge clk)
        $past(rst) |-> taps[0]);

endmodule

// File: rtl/wiper_position_unit.sv
module wiper_position_unit
    import wiper_pkg::*;
#(
    parameter int POS_W       = 6,
    parameter int BANK_N      = 4,
    parameter int RECALL_WAIT = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      host_wr_en,
    input  logic [POS_W-1:0]          host_wr_data,
    input  logic                      xfer_en,
    input  logic [$clog2(BANK_N)-1:0] xfer_sel,
    input  logic [BANK_N*POS_W-1:0]   bank_data,
    input  logic                      step_en,
    input  logic                      step_up,
    output logic [POS_W-1:0]          pos_out,
    output logic [(1<<POS_W)-1:0]     tap_sel
);
    localparam logic [POS_W-1:0] POS_TOP = '1;

    logic             busy;
    logic             fire;
    pos_req_t         req;
    pos_src_e         src;
    logic [POS_W-1:0] nxt;
    logic [POS_W-1:0] pos_q;

    assign req = '{wr: host_wr_en, xfer: xfer_en, step: step_en, up: step_up};

    wiper_recall_seq #(.RECALL_WAIT(RECALL_WAIT)) u_recall (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .fire (fire)
    );

    wiper_next_sel #(.POS_W(POS_W), .BANK_N(BANK_N)) u_sel (
        .busy      (busy),
        .fire      (fire),
        .req       (req),
        .wr_data   (host_wr_data),
        .xfer_sel  (xfer_sel),
        .bank_data (bank_data),
        .cur       (pos_q),
        .src       (src),
        .nxt       (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (src != SRC_HOLD)
            pos_q <= nxt;
    end

    wiper_tap_decoder #(.POS_W(POS_W)) u_dec (
        .clk  (clk),
        .rst  (rst),
        .pos  (pos_q),
        .taps (tap_sel)
    );

    assign pos_out = pos_q;

    // R2
    recall_load_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> pos_q == $past(bank_data[POS_W-1:0]));

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire) |=> $stable(pos_q));

    // R3
    wr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_WRITE) |=> pos_q == $past(host_wr_data));

    // R4
    xfer_load_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_XFER) |=> pos_q == $past(bank_data[xfer_sel*POS_W +: POS_W]));

    // R5
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_STEP && step_up && pos_q != POS_TOP) |=> pos_q == $past(pos_q) + POS_W'(1));

    // R6
    sat_top_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_STEP && step_up && pos_q == POS_TOP) |=> $stable(pos_q));

    // R6
    sat_bottom_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_STEP && !step_up && pos_q == '0) |=> $stable(pos_q));

    // R7
    prio_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && host_wr_en) |-> src == SRC_WRITE);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !host_wr_en && !xfer_en && !step_en) |=> $stable(pos_q));

endmodule

// File: tb/test_wiper_position_unit.sv
module test_wiper_position_unit;
    localparam int  W    = 6;
    localparam int  WAIT = 4;
    localparam time TCK  = 20ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr_en = 1'b0;
    logic [W-1:0]  host_wr_data = '0;
    logic          xfer_en = 1'b0;
    logic [1:0]    xfer_sel = '0;
    logic [4*W-1:0] bank_data = {6'h2A, 6'h01, 6'h3E, 6'h15};
    logic          step_en = 1'b0;
    logic          step_up = 1'b0;
    logic [W-1:0]  pos_out;
    logic [63:0]   tap_sel;

    int checks = 0;
    int errors = 0;

    always #(TCK/2) clk = ~clk;

    wiper_position_unit i_wiper_position_unit (
        .clk          (clk),
        .rst          (rst),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .xfer_en      (xfer_en),
        .xfer_sel     (xfer_sel),
        .bank_data    (bank_data),
        .step_en      (step_en),
        .step_up      (step_up),
        .pos_out      (pos_out),
        .tap_sel      (tap_sel)
    );

    // {wr, wdata[5:0], xfer, xsel[1:0], step, up, expected[5:0]}
    localparam int NV = 14;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b1, 6'h16}, // R5 up
        {1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b0, 6'h15}, // R5 down
        {1'b1, 6'h3F, 1'b0, 2'd0, 1'b0, 1'b0, 6'h3F}, // R3, R8 high end
        {1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b1, 6'h3F}, // R6 top
        {1'b0, 6'h00, 1'b1, 2'd1, 1'b0, 1'b0, 6'h3E}, // R4 entry 1
        {1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b1, 6'h3F}, // R5 up to top
        {1'b1, 6'h00, 1'b0, 2'd0, 1'b0, 1'b0, 6'h00}, // R3, R8 low end
        {1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b0, 6'h00}, // R6 bottom
        {1'b0, 6'h00, 1'b1, 2'd2, 1'b0, 1'b0, 6'h01}, // R4 entry 2
        {1'b0, 6'h00, 1'b0, 2'd0, 1'b1, 1'b0, 6'h00}, // R5 down to bottom
        {1'b1, 6'h20, 1'b1, 2'd3, 1'b1, 1'b1, 6'h20}, // R7 write wins
        {1'b0, 6'h00, 1'b1, 2'd3, 1'b1, 1'b0, 6'h2A}, // R7 transfer beats step
        {1'b0, 6'h00, 1'b0, 2'd0, 1'b0, 1'b0, 6'h2A}, // R9 hold
        {1'b0, 6'h00, 1'b1, 2'd0, 1'b0, 1'b0, 6'h15}  // R4 entry 0
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_strobes();
        host_wr_en = 1'b0;
        xfer_en    = 1'b0;
        step_en    = 1'b0;
        step_up    = 1'b0;
    endtask

    initial begin
        #(TCK * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pos in reset", 64'(pos_out), 64'h0);
        chk("R1 tap in reset", tap_sel, 64'h1);

        // release reset with a write pending: must be ignored until recall
        rst          = 1'b0;
        host_wr_en   = 1'b1;
        host_wr_data = 6'h33;
        step_en      = 1'b1;
        step_up      = 1'b1;
        repeat (WAIT) @(posedge clk);
        @(negedge clk);
        chk("R2 strobes ignored before recall", 64'(pos_out), 64'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 recall of entry 0", 64'(pos_out), 64'h15);
        chk("R8 tap after recall", tap_sel, 64'(1) << 6'h15);
        clear_strobes();

        for (int i = 0; i < NV; i++) begin
            host_wr_en   = VEC[i][17];
            host_wr_data = VEC[i][16:11];
            xfer_en      = VEC[i][10];
            xfer_sel     = VEC[i][9:8];
            step_en      = VEC[i][7];
            step_up      = VEC[i][6];
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R3/R4/R5/R6/R7/R9 vector %0d pos", i), 64'(pos_out), 64'(VEC[i][5:0]));
            chk($sformatf("R8 vector %0d tap", i), tap_sel, 64'(1) << VEC[i][5:0]);
        end
        clear_strobes();

        // second reset: recall uses entry 0, not the value before reset
        bank_data[W-1:0] = 6'h07;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1 pos in second reset", 64'(pos_out), 64'h0);
        chk("R1 tap in second reset", tap_sel, 64'h1);
        rst = 1'b0;
        repeat (WAIT + 1) @(posedge clk);
        @(negedge clk);
        chk("R2 recall after second reset", 64'(pos_out), 64'h07);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule